// File: doc/BRIEF.md
# SPI register-access slave

This block sits between an SPI bus master and a simple parallel register bus. It receives serial frames and turns them into register read and write strobes, with an address, write data and read data. Each frame starts with one command byte. The command byte holds the transfer direction, an address-increment flag and a 6-bit register address. One or more data bytes follow the command byte. A burst either stays on one register or moves through consecutive registers.

The SPI pins are sampled with the system clock, which must run several times faster than the serial clock. A configuration input selects where read data leaves the block:

- In 4-wire operation, read data goes out on a dedicated output.
- In 3-wire operation, read data is driven back onto the shared serial data line, and the master releases that line for the data phase.

The register file sits outside the block. It returns the read data for the presented address, and it returns a hit flag that says whether that address exists.

Top module: `spi_reg_slave`

## Requirements
- R1: Chip select is active low. While it is high, serial clock edges are ignored and no register strobe is issued.
- R2: Serial data is sampled on rising clock edges, MSb first. In the command byte, bit 7 is the direction (1 = read, 0 = write), bit 6 enables address increment, and bits 5:0 are the register address.
- R3: A write frame of 16 clocks issues exactly one single-cycle write strobe, carrying the command address and the data byte.
- R4: Each further 8 clocks of a write frame issues one more write strobe. With the increment bit at 0, every strobe uses the command address. With the increment bit at 1, the address rises by one per byte and wraps modulo 64.
- R5: In a read frame, the block drives read data MSb first, starting from the falling edge that opens bit 8. The output changes only after falling edges and after a read-strobe load.
- R6: Read bursts follow the same addressing as write bursts: the address repeats when the increment bit is 0, and steps by one with wrap modulo 64 when it is 1.
- R7: Each read byte gets exactly one single-cycle read strobe. The strobe is issued in the cycle before that byte is loaded for shifting. The first read byte uses the command address. Read and write strobes never coincide.
- R8: With three_wire_i = 0, read data appears on sdo_o under sdo_oe_o, and the shared line is not driven. With three_wire_i = 1, read data appears on sdi_o under sdi_oe_o, and sdo_oe_o stays low. The two enables are never both high.
- R9: When reg_hit_i is low for the presented address, a read returns 0x00 whatever reg_rdata_i holds, and a write issues no write strobe.
- R10: Both output enables are low whenever chip select is high and throughout write frames.
- R11: A byte not fully clocked when chip select rises issues no strobe. This applies to a partial command byte as well. A complete command byte with no data byte issues no strobe.
- R12: After reset, both output enables and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| three_wire_i | input | 1 | 0: 4-wire operation, 1: 3-wire operation |
| csn_i | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data in (the shared data line in 3-wire operation) |
| sdi_o | output | 1 | Read data driven onto the shared line in 3-wire operation |
| sdi_oe_o | output | 1 | Drive enable for the shared line |
| sdo_o | output | 1 | Read data output in 4-wire operation |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| reg_addr_o | output | 6 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_re_o | output | 1 | Single-cycle read strobe |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, combinational |
| reg_hit_i | input | 1 | High when reg_addr_o names an existing register |

## Verification
The bench targets these corner cases:

- **Address wrap.** A read burst wraps from address 63 to 0. A design with the wrong wrap or step reads from the wrong register.
- **Undefined register in a burst.** A write burst walks off the end of the defined registers. A design that fails to gate the strobe corrupts the register aliased by the low address bits. A design that fails to zero the read path returns that register's content instead of 0x00.
- **Partial final byte.** A frame ends partway through a data byte, and another ends partway through the command byte. A design that commits partial bytes issues an extra strobe, which shows up as a changed register on readback.
- **3-wire turnaround.** A design that drives the wrong pin, or starts driving late, makes the master sample the pulled-up idle level instead of the data.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int unsigned SPI_DATA_W = 8;
  localparam int unsigned SPI_SYNC_STAGES = 2;

  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } dir_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_regs_pkg::*;
#(
  parameter int unsigned DATA_W = SPI_DATA_W,
  parameter int unsigned ADDR_W = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sck_fall_o,
  output logic              byte_start_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_pend_o,
  output logic              rd_stb_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              sck_q;
  logic [CNT_W-1:0]  bit_q;
  logic              hdr_done_q;
  logic              first_q;
  dir_e              dir_q;
  logic              inc_q;
  logic [DATA_W-2:0] rx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_pend_q;
  logic              rd_stb_q;

  logic              sck_rise;
  logic              sck_fall;
  logic              byte_end;
  logic              byte_start;
  logic [DATA_W-1:0] rx_byte;

  assign sck_rise   = sck_i & ~sck_q & ~csn_i;
  assign sck_fall   = ~sck_i & sck_q & ~csn_i;
  assign rx_byte    = {rx_q, sdi_i};
  assign byte_end   = sck_rise && (bit_q == LAST_BIT);
  // falling edge that opens a read data byte
  assign byte_start = sck_fall && hdr_done_q && (dir_q == DIR_RD) && (bit_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= 1'b1;
      bit_q      <= '0;
      hdr_done_q <= 1'b0;
      first_q    <= 1'b1;
      dir_q      <= DIR_WR;
      inc_q      <= 1'b0;
      rx_q       <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      wr_pend_q  <= 1'b0;
      rd_stb_q   <= 1'b0;
    end else begin
      sck_q     <= sck_i;
      wr_pend_q <= 1'b0;
      rd_stb_q  <= 1'b0;
      // step after a committed write
      if (wr_pend_q && inc_q) addr_q <= addr_q + ONE;
      if (csn_i) begin
        bit_q      <= '0;
        hdr_done_q <= 1'b0;
        first_q    <= 1'b1;
        dir_q      <= DIR_WR;
      end else begin
        if (sck_rise) begin
          rx_q  <= rx_byte[DATA_W-2:0];
          bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + CNT_W'(1);
          if (byte_end) begin
            if (!hdr_done_q) begin
              hdr_done_q <= 1'b1;
              dir_q      <= dir_e'(rx_byte[DATA_W-1]);
              inc_q      <= rx_byte[DATA_W-2];
              addr_q     <= rx_byte[ADDR_W-1:0];
            end else if (dir_q == DIR_WR) begin
              wdata_q   <= rx_byte;
              wr_pend_q <= 1'b1;
            end
          end
        end
        if (byte_start) begin
          rd_stb_q <= 1'b1;
          first_q  <= 1'b0;
          if (!first_q && inc_q) addr_q <= addr_q + ONE;
        end
      end
    end
  end

  assign sck_fall_o   = sck_fall;
  assign byte_start_o = byte_start;
  assign addr_o       = addr_q;
  assign wdata_o      = wdata_q;
  assign wr_pend_o    = wr_pend_q;
  assign rd_stb_o     = rd_stb_q;
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_regs_pkg::*;
#(
  parameter int unsigned DATA_W = SPI_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sck_fall_i,
  input  logic              byte_start_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              hit_i,
  input  logic              three_wire_i,
  output logic              sd_o,
  output logic              sdi_oe_o,
  output logic              sdo_oe_o
);
  logic [DATA_W-1:0] tx_q;
  logic              drv_q;
  logic              oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      drv_q <= 1'b0;
    end else if (csn_i) begin
      drv_q <= 1'b0;
    end else if (load_i) begin
      tx_q  <= hit_i ? rdata_i : '0;
      drv_q <= 1'b1;
    end else if (sck_fall_i && drv_q && !byte_start_i) begin
      // hold the last bit until the next byte is loaded
      tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  assign oe       = drv_q & ~csn_i;
  assign sd_o     = tx_q[DATA_W-1];
  assign sdi_oe_o = oe & three_wire_i;
  assign sdo_oe_o = oe & ~three_wire_i;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_regs_pkg::*;
#(
  parameter int unsigned DATA_W = SPI_DATA_W,
  parameter int unsigned SYNC_STAGES = SPI_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              three_wire_i,
  input  logic              csn_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdi_o,
  output logic              sdi_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-3:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_hit_i
);
  localparam int unsigned ADDR_W = DATA_W - 2;

  logic [2:0] sync_q;
  logic       csn_s;
  logic       sck_s;
  logic       sdi_s;
  logic       sck_fall;
  logic       byte_start;
  logic       wr_pend;
  logic       rd_stb;
  logic       sd;

  spi_pin_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sck_i, sdi_i}),
    .q_o   (sync_q)
  );

  assign csn_s = sync_q[2];
  assign sck_s = sync_q[1];
  assign sdi_s = sync_q[0];

  spi_rx_frame #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csn_i       (csn_s),
    .sck_i       (sck_s),
    .sdi_i       (sdi_s),
    .sck_fall_o  (sck_fall),
    .byte_start_o(byte_start),
    .addr_o      (reg_addr_o),
    .wdata_o     (reg_wdata_o),
    .wr_pend_o   (wr_pend),
    .rd_stb_o    (rd_stb)
  );

  spi_tx_shift #(
    .DATA_W(DATA_W)
  ) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csn_i       (csn_s),
    .sck_fall_i  (sck_fall),
    .byte_start_i(byte_start),
    .load_i      (rd_stb),
    .rdata_i     (reg_rdata_i),
    .hit_i       (reg_hit_i),
    .three_wire_i(three_wire_i),
    .sd_o        (sd),
    .sdi_oe_o    (sdi_oe_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  assign sdi_o    = sd;
  assign sdo_o    = sd;
  assign reg_we_o = wr_pend & reg_hit_i;
  assign reg_re_o = rd_stb;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic csn_s,
  input logic sck_fall,
  input logic three_wire_i,
  input logic sdi_oe_o,
  input logic sdo_oe_o,
  input logic sdo_o,
  input logic reg_we_o,
  input logic reg_re_o
);
  a_r1_no_strobe_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_s && $past(csn_s)) |-> (!reg_we_o && !reg_re_o));

  a_r8_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdi_oe_o && sdo_oe_o));

  a_r8_shared_pin_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdi_oe_o |-> three_wire_i);

  a_r7_read_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  a_r3_write_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  a_r7_drive_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o || sdi_oe_o) |-> $past(reg_re_o));

  a_r5_hold_between_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$past(sck_fall) && !$past(reg_re_o)) |-> $stable(sdo_o));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csn_s       (csn_s),
  .sck_fall    (sck_fall),
  .three_wire_i(three_wire_i),
  .sdi_oe_o    (sdi_oe_o),
  .sdo_oe_o    (sdo_oe_o),
  .sdo_o       (sdo_o),
  .reg_we_o    (reg_we_o),
  .reg_re_o    (reg_re_o)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
module sim_spi_reg_slave;
  typedef struct packed {
    logic       tw;
    logic       rd;
    logic       inc;
    logic [5:0] addr;
    logic [3:0] nb;
    logic [7:0] seed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 6'd3,  4'd1, 8'h5A},
    '{1'b0, 1'b0, 1'b1, 6'd4,  4'd3, 8'h11},
    '{1'b0, 1'b0, 1'b0, 6'd7,  4'd3, 8'h22},
    '{1'b0, 1'b1, 1'b0, 6'd4,  4'd1, 8'h00},
    '{1'b0, 1'b1, 1'b1, 6'd4,  4'd4, 8'h00},
    '{1'b1, 1'b1, 1'b0, 6'd7,  4'd2, 8'h00},
    '{1'b1, 1'b0, 1'b1, 6'd14, 4'd3, 8'h33},
    '{1'b0, 1'b1, 1'b1, 6'd14, 4'd3, 8'h00},
    '{1'b0, 1'b0, 1'b0, 6'd40, 4'd1, 8'h44},
    '{1'b1, 1'b1, 1'b1, 6'd62, 4'd3, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tw = 1'b0;
  logic m_csn = 1'b1;
  logic m_sck = 1'b1;
  logic m_dout = 1'b0;
  logic m_den = 1'b1;

  logic       sdi_o, sdi_oe, sdo_o, sdo_oe;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we, reg_re, reg_hit;
  logic       sdi_line, miso_line;

  logic [7:0] regs [16];
  logic [7:0] exp_regs [16];
  logic [5:0] we_a [16];
  logic [7:0] we_d [16];
  logic [5:0] re_a [16];
  int n_we, n_re;
  logic [7:0] rx_b [8];
  int stray;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sdi_line  = sdi_oe ? sdi_o : (m_den ? m_dout : 1'b1);
  assign miso_line = sdo_oe ? sdo_o : 1'b1;
  assign reg_hit   = (reg_addr < 6'd16);
  assign reg_rdata = regs[reg_addr[3:0]];

  spi_reg_slave u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .three_wire_i(tw),
    .csn_i       (m_csn),
    .sck_i       (m_sck),
    .sdi_i       (sdi_line),
    .sdi_o       (sdi_o),
    .sdi_oe_o    (sdi_oe),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_re_o    (reg_re),
    .reg_rdata_i (reg_rdata),
    .reg_hit_i   (reg_hit)
  );

  // register file model and strobe log
  always @(posedge clk) begin
    if (reg_we) begin
      regs[reg_addr[3:0]] <= reg_wdata;
      if (n_we < 16) begin
        we_a[n_we] <= reg_addr;
        we_d[n_we] <= reg_wdata;
      end
      n_we <= n_we + 1;
    end
    if (reg_re) begin
      if (n_re < 16) re_a[n_re] <= reg_addr;
      n_re <= n_re + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [7:0] wbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  function automatic logic [5:0] step(input logic [5:0] a, input logic inc, input int i);
    return inc ? a + 6'(i) : a;
  endfunction

  task automatic clear_logs();
    n_we = 0;
    n_re = 0;
    stray = 0;
    for (int i = 0; i < 8; i++) rx_b[i] = 8'h00;
  endtask

  task automatic xfer(input logic rd, input logic inc, input logic [5:0] addr,
                      input int nbits, input logic [7:0] seed);
    logic [7:0] hdr;
    logic [7:0] wb;
    logic       smp;
    hdr = {rd, inc, addr};
    clear_logs();
    m_csn = 1'b0;
    half();
    for (int k = 0; k < nbits; k++) begin
      m_sck = 1'b0;
      if (k < 8) begin
        m_den = 1'b1;
        m_dout = hdr[7-k];
      end else if (rd) begin
        m_den = !tw;
        m_dout = 1'b0;
      end else begin
        wb = wbyte(seed, (k - 8) / 8);
        m_den = 1'b1;
        m_dout = wb[7-(k%8)];
      end
      half();
      if (k >= 8 && rd) begin
        smp = tw ? sdi_line : miso_line;
        if ((k - 8) / 8 < 8) rx_b[(k-8)/8][7-(k%8)] = smp;
        if (tw ? (!sdi_oe || sdo_oe) : (!sdo_oe || sdi_oe)) stray++;
      end else if (sdo_oe || sdi_oe) begin
        stray++;
      end
      m_sck = 1'b1;
      half();
    end
    m_den = 1'b1;
    m_csn = 1'b1;
    half();
    half();
    if (sdo_oe || sdi_oe) stray++;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      regs[i] = 8'hC3 ^ 8'(i * 17);
      exp_regs[i] = 8'hC3 ^ 8'(i * 17);
    end
    n_we = 0;
    n_re = 0;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(!sdo_oe && !sdi_oe && !reg_we && !reg_re, "R12", "outputs in reset", {sdo_oe, sdi_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdo_oe && !sdi_oe && !reg_we && !reg_re, "R12", "outputs after reset", {sdo_oe, sdi_oe, reg_we, reg_re}, 0);

    // R1: clock toggles while deselected are ignored
    clear_logs();
    for (int i = 0; i < 12; i++) begin
      m_sck = 1'b0; m_dout = i[0]; half();
      m_sck = 1'b1; half();
    end
    chk(n_we == 0 && n_re == 0, "R1", "strobes while deselected", n_we + n_re, 0);

    for (int v = 0; v < NV; v++) begin
      vec_t c;
      int j;
      int exp_n;
      logic [5:0] a;
      logic [7:0] e;
      c = VECS[v];
      tw = c.tw;
      xfer(c.rd, c.inc, c.addr, 8 + 8 * int'(c.nb), c.seed);
      chk(stray == 0, "R8 R10", $sformatf("vector %0d drive enables", v), stray, 0);
      if (!c.rd) begin
        exp_n = 0;
        for (int i = 0; i < int'(c.nb); i++) if (step(c.addr, c.inc, i) < 6'd16) exp_n++;
        chk(n_we == exp_n, "R3 R4 R9", $sformatf("vector %0d write count", v), n_we, exp_n);
        chk(n_re == 0, "R7", $sformatf("vector %0d no read strobe", v), n_re, 0);
        j = 0;
        for (int i = 0; i < int'(c.nb); i++) begin
          a = step(c.addr, c.inc, i);
          if (a < 6'd16) begin
            e = wbyte(c.seed, i);
            chk(j < n_we && we_a[j] == a, "R2 R4", $sformatf("vector %0d write addr %0d", v, i), we_a[j], a);
            chk(j < n_we && we_d[j] == e, "R3", $sformatf("vector %0d write data %0d", v, i), we_d[j], e);
            exp_regs[a[3:0]] = e;
            j++;
          end
        end
      end else begin
        chk(n_re == int'(c.nb), "R7", $sformatf("vector %0d read strobe count", v), n_re, c.nb);
        for (int i = 0; i < int'(c.nb); i++) begin
          a = step(c.addr, c.inc, i);
          e = (a < 6'd16) ? exp_regs[a[3:0]] : 8'h00;
          chk(rx_b[i] == e, "R5 R9", $sformatf("vector %0d read byte %0d", v, i), rx_b[i], e);
          chk(re_a[i] == a, "R6 R7", $sformatf("vector %0d read addr %0d", v, i), re_a[i], a);
        end
      end
    end

    // R11: trailing partial data byte is dropped
    tw = 1'b0;
    xfer(1'b0, 1'b1, 6'd2, 8 + 8 + 5, 8'h77);
    chk(n_we == 1, "R11", "partial byte write count", n_we, 1);
    chk(we_a[0] == 6'd2 && we_d[0] == 8'h77, "R11", "complete byte written", {we_a[0], we_d[0]}, {6'd2, 8'h77});
    exp_regs[2] = 8'h77;
    xfer(1'b1, 1'b1, 6'd2, 24, 8'h00);
    chk(rx_b[0] == exp_regs[2], "R11", "readback of written byte", rx_b[0], exp_regs[2]);
    chk(rx_b[1] == exp_regs[3], "R11", "neighbour untouched by partial byte", rx_b[1], exp_regs[3]);

    // R11: partial header and header-only frames
    xfer(1'b0, 1'b0, 6'd5, 5, 8'h00);
    chk(n_we == 0 && n_re == 0, "R11", "partial command strobes", n_we + n_re, 0);
    xfer(1'b0, 1'b0, 6'd5, 8, 8'h00);
    chk(n_we == 0 && n_re == 0, "R11", "command-only strobes", n_we + n_re, 0);
    chk(stray == 0, "R10", "enables in command-only write", stray, 0);

    // R1: deselected idle after traffic
    repeat (20) @(negedge clk);
    chk(!sdo_oe && !sdi_oe, "R1 R10", "enables while deselected", {sdo_oe, sdi_oe}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule